// File: doc/BRIEF.md
# Timer Channel Event Flag Register

This block keeps the sticky event flags of one channel of a 16-bit timer. Single-cycle event pulses from the surrounding counter and compare/capture logic set the flags. The host processor reads them through a simple register port and clears them through the same port. A transfer controller that services a flag's request can also clear that flag. Each flag, gated by its own enable, drives a level interrupt request.

A flag is cleared by software only after a handshake. A register read must first return the flag as 1, which arms it. A later write of 0 to that bit then clears it. Any register write disarms every flag, so a second write without a fresh read clears nothing. A parameter selects the channel type. The four-register type has capture/compare flags A to D and an overflow flag. The two-register, phase-counting type has flags A and B, overflow and underflow. Bits that a type lacks read as 0 and cannot be changed.

Flag bit layout (read and write): bit 0 = flag A, bit 1 = flag B, bit 2 = flag C, bit 3 = flag D, bit 4 = overflow, bit 5 = underflow.

Top module: `tstat_flags`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, every flag and every interrupt request reads 0.
- R2: When `cnt_upd_i` is high with `cnt_cur_i` = 0xFFFF and `cnt_nxt_i` = 0x0000, bit 4 reads 1 from the following cycle on. Any other update leaves it unchanged.
- R3: When `cnt_upd_i` is high with `cnt_cur_i` = 0x0000 and `cnt_nxt_i` = 0xFFFF while `phase_mode_i` is 1, bit 5 of the two-register type reads 1 from the following cycle on. With `phase_mode_i` at 0 the same update sets nothing.
- R4: General flag i (bits 0 to 3) sets the cycle after `gr_cmp_hit_i[i]` when `gr_cap_mode_i[i]` is 0. It sets the cycle after `gr_cap_edge_i[i]` when `gr_cap_mode_i[i]` is 1. The pulse of the unselected source has no effect.
- R5: A write with bit k = 0 clears flag k only if a read since the previous write returned bit k as 1. A write without such a read leaves the flag set.
- R6: Writing 1 to any bit leaves that flag unchanged. Software can never set a flag.
- R7: Any write disarms all flags. A write of 0 that follows an earlier write, with no read in between, clears nothing.
- R8: `xfer_ack_i[i]` clears general flag i when `xfer_keep_i` is 0. It has no effect when `xfer_keep_i` is 1.
- R9: When a set event and any clear condition hit the same flag in the same cycle, the flag reads 1 afterwards.
- R10: On the four-register type bit 5 always reads 0. On the two-register type bits 2 and 3 always read 0. Neither events nor writes change these bits.
- R11: `irq_o[k]` equals flag k ANDed with `irq_en_i[k]`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_upd_i | input | 1 | Counter changes value this cycle |
| cnt_cur_i | input | CNT_W | Counter value before the change |
| cnt_nxt_i | input | CNT_W | Counter value after the change |
| phase_mode_i | input | 1 | Channel runs in phase-counting mode |
| gr_cap_mode_i | input | 4 | Per general register: 1 = input capture, 0 = output compare |
| gr_cmp_hit_i | input | 4 | Per general register: counter equals register this cycle |
| gr_cap_edge_i | input | 4 | Per general register: capture edge latched counter this cycle |
| xfer_ack_i | input | 4 | Transfer controller started a transfer for this flag's request |
| xfer_keep_i | input | 1 | Controller disable-after-transfer select; 1 keeps the flag |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 6 | Write data, one bit per flag |
| rdata_o | output | 6 | Read data, one bit per flag |
| irq_en_i | input | 6 | Per-flag interrupt enable |
| irq_o | output | 6 | Per-flag level interrupt request |

## Verification
A wrong arm state has no immediate effect at the ports. It shows up at the next write of 0, one cycle later, as a flag that stays up when it should have cleared, or one that drops when it should have stayed. The bench therefore runs read-then-write, write-then-write and write-without-read sequences and checks `rdata_o` after each one. A wrong event select or a missed wrap shows up at `rdata_o` and `irq_o` in the cycle right after the pulse. Both channel types are driven in lock-step, so a bit that is reserved on one type must stay at 0 while the same bit on the other type sets.

// File: rtl/tstat_pkg.sv
`timescale 1ns/1ps
package tstat_pkg;

  typedef enum logic [0:0] {
    CH_QUAD  = 1'b0,  // four general registers, no underflow
    CH_PHASE = 1'b1   // two general registers, phase counting
  } ch_type_e;

  localparam int NUM_GR  = 4;
  localparam int NFLAG   = NUM_GR + 2;
  localparam int IDX_OVF = NUM_GR;
  localparam int IDX_UNF = NUM_GR + 1;

  typedef logic [NFLAG-1:0]  flag_vec_t;
  typedef logic [NUM_GR-1:0] gr_vec_t;

  // Which flag bits physically exist for a channel type.
  function automatic flag_vec_t impl_mask(ch_type_e t);
    flag_vec_t m;
    m = '1;
    if (t == CH_QUAD) begin
      m[IDX_UNF] = 1'b0;
    end else begin
      m[2] = 1'b0;
      m[3] = 1'b0;
    end
    return m;
  endfunction

endpackage

// File: rtl/tstat_wrap_det.sv
`timescale 1ns/1ps
module tstat_wrap_det #(
  parameter int CNT_W = 16
) (
  input  logic             upd_i,
  input  logic [CNT_W-1:0] cur_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic             phase_i,
  output logic             ovf_o,
  output logic             unf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  function automatic logic up_wrap(logic [CNT_W-1:0] a, logic [CNT_W-1:0] b);
    return (a == CNT_MAX) && (b == CNT_ZERO);
  endfunction

  function automatic logic down_wrap(logic [CNT_W-1:0] a, logic [CNT_W-1:0] b);
    return (a == CNT_ZERO) && (b == CNT_MAX);
  endfunction

  assign ovf_o = upd_i && up_wrap(cur_i, nxt_i);
  assign unf_o = upd_i && phase_i && down_wrap(cur_i, nxt_i);

endmodule

// File: rtl/tstat_evt_sel.sv
`timescale 1ns/1ps
module tstat_evt_sel #(
  parameter int N = 4
) (
  input  logic [N-1:0] cap_mode_i,
  input  logic [N-1:0] cmp_hit_i,
  input  logic [N-1:0] cap_edge_i,
  output logic [N-1:0] evt_o
);

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign evt_o[g] = cap_mode_i[g] ? cap_edge_i[g] : cmp_hit_i[g];
  end

endmodule

// File: rtl/tstat_flag_cell.sv
`timescale 1ns/1ps
module tstat_flag_cell #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic xclr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic arm_o
);

  logic flag_q, arm_q;
  logic sw_clr;
  logic flag_d, arm_d;

  assign sw_clr = wr_i && arm_q && !wbit_i;

  always_comb begin
    flag_d = IMPL && (set_i || (flag_q && !sw_clr && !xclr_i));
    if (wr_i) arm_d = 1'b0;
    else      arm_d = IMPL && (arm_q || (rd_i && flag_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;

endmodule

// File: rtl/tstat_flags.sv
`timescale 1ns/1ps
module tstat_flags #(
  parameter tstat_pkg::ch_type_e CH_TYPE = tstat_pkg::CH_QUAD,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cnt_upd_i,
  input  logic [CNT_W-1:0]           cnt_cur_i,
  input  logic [CNT_W-1:0]           cnt_nxt_i,
  input  logic                       phase_mode_i,
  input  logic [tstat_pkg::NUM_GR-1:0] gr_cap_mode_i,
  input  logic [tstat_pkg::NUM_GR-1:0] gr_cmp_hit_i,
  input  logic [tstat_pkg::NUM_GR-1:0] gr_cap_edge_i,
  input  logic [tstat_pkg::NUM_GR-1:0] xfer_ack_i,
  input  logic                       xfer_keep_i,
  input  logic                       rd_en_i,
  input  logic                       wr_en_i,
  input  logic [tstat_pkg::NFLAG-1:0]  wdata_i,
  output logic [tstat_pkg::NFLAG-1:0]  rdata_o,
  input  logic [tstat_pkg::NFLAG-1:0]  irq_en_i,
  output logic [tstat_pkg::NFLAG-1:0]  irq_o
);

  import tstat_pkg::*;

  localparam flag_vec_t MASK = impl_mask(CH_TYPE);

  // Named internal events, visible to the checker.
  logic      ovf_evt, unf_evt;
  gr_vec_t   gr_evt;
  flag_vec_t set_vec;
  flag_vec_t clr_xfer_vec;
  flag_vec_t flag_vec;
  flag_vec_t arm_vec;

  tstat_wrap_det #(.CNT_W(CNT_W)) wrap_i (
    .upd_i   (cnt_upd_i),
    .cur_i   (cnt_cur_i),
    .nxt_i   (cnt_nxt_i),
    .phase_i (phase_mode_i),
    .ovf_o   (ovf_evt),
    .unf_o   (unf_evt)
  );

  tstat_evt_sel #(.N(NUM_GR)) sel_i (
    .cap_mode_i (gr_cap_mode_i),
    .cmp_hit_i  (gr_cmp_hit_i),
    .cap_edge_i (gr_cap_edge_i),
    .evt_o      (gr_evt)
  );

  assign set_vec      = {unf_evt, ovf_evt, gr_evt};
  assign clr_xfer_vec = {2'b00, xfer_ack_i & {NUM_GR{!xfer_keep_i}}};

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    tstat_flag_cell #(.IMPL(MASK[k])) cell_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[k]),
      .xclr_i (clr_xfer_vec[k]),
      .rd_i   (rd_en_i),
      .wr_i   (wr_en_i),
      .wbit_i (wdata_i[k]),
      .flag_o (flag_vec[k]),
      .arm_o  (arm_vec[k])
    );
  end

  assign rdata_o = flag_vec;
  assign irq_o   = flag_vec & irq_en_i;

endmodule

// File: rtl/tstat_flags_chk.sv
`timescale 1ns/1ps
module tstat_flags_chk #(
  parameter tstat_pkg::ch_type_e CH_TYPE = tstat_pkg::CH_QUAD
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en_i,
  input logic [tstat_pkg::NFLAG-1:0] set_vec,
  input logic [tstat_pkg::NFLAG-1:0] clr_xfer_vec,
  input logic [tstat_pkg::NFLAG-1:0] arm_vec,
  input logic [tstat_pkg::NFLAG-1:0] rdata_o
);

  localparam tstat_pkg::flag_vec_t MASK = tstat_pkg::impl_mask(CH_TYPE);

  assert_write_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (arm_vec == '0));

  for (genvar k = 0; k < tstat_pkg::NFLAG; k++) begin : g_chk
    if (MASK[k]) begin : g_impl
      // R9: an event always lands, whatever clears in the same cycle.
      assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[k] |=> rdata_o[k]);
      // R6: without an event a flag cannot rise.
      assert_no_self_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_vec[k] && !rdata_o[k]) |=> !rdata_o[k]);
      // R5: a write to an unarmed flag leaves it set.
      assert_unarmed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !arm_vec[k] && rdata_o[k] && !clr_xfer_vec[k]) |=> rdata_o[k]);
    end else begin : g_rsvd
      assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[k] |=> !rdata_o[k]);
    end
  end

endmodule

bind tstat_flags tstat_flags_chk #(.CH_TYPE(CH_TYPE)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en_i      (wr_en_i),
  .set_vec      (set_vec),
  .clr_xfer_vec (clr_xfer_vec),
  .arm_vec      (arm_vec),
  .rdata_o      (rdata_o)
);

// File: tb/tstat_flags_tb.sv
`timescale 1ns/1ps
module tstat_flags_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_upd = 1'b0;
  logic [15:0] cnt_cur = '0;
  logic [15:0] cnt_nxt = '0;
  logic        phase_mode = 1'b0;
  logic [3:0]  cap_mode = '0, cmp_hit = '0, cap_edge = '0, xack = '0;
  logic        xkeep = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0]  wdata = '0;
  logic [5:0]  irq_en = '1;
  logic [5:0]  rd_a, rd_b, irq_a, irq_b;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tstat_flags #(.CH_TYPE(tstat_pkg::CH_QUAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_upd_i(cnt_upd), .cnt_cur_i(cnt_cur),
    .cnt_nxt_i(cnt_nxt), .phase_mode_i(phase_mode), .gr_cap_mode_i(cap_mode),
    .gr_cmp_hit_i(cmp_hit), .gr_cap_edge_i(cap_edge), .xfer_ack_i(xack),
    .xfer_keep_i(xkeep), .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rd_a), .irq_en_i(irq_en), .irq_o(irq_a));

  tstat_flags #(.CH_TYPE(tstat_pkg::CH_PHASE)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .cnt_upd_i(cnt_upd), .cnt_cur_i(cnt_cur),
    .cnt_nxt_i(cnt_nxt), .phase_mode_i(phase_mode), .gr_cap_mode_i(cap_mode),
    .gr_cmp_hit_i(cmp_hit), .gr_cap_edge_i(cap_edge), .xfer_ack_i(xack),
    .xfer_keep_i(xkeep), .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rd_b), .irq_en_i(irq_en), .irq_o(irq_b));

  typedef struct {
    string      tag;
    logic [5:0] ea, eb, ia, ib;
  } item_t;

  item_t sb_q[$];

  // Monitor: compare queued expectations away from the active edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk += 4;
      if (rd_a !== it.ea) begin
        n_bad++; $display("FAIL %s quad rdata actual=%h expected=%h", it.tag, rd_a, it.ea);
      end
      if (rd_b !== it.eb) begin
        n_bad++; $display("FAIL %s phase rdata actual=%h expected=%h", it.tag, rd_b, it.eb);
      end
      if (irq_a !== it.ia) begin
        n_bad++; $display("FAIL %s quad irq actual=%h expected=%h", it.tag, irq_a, it.ia);
      end
      if (irq_b !== it.ib) begin
        n_bad++; $display("FAIL %s phase irq actual=%h expected=%h", it.tag, irq_b, it.ib);
      end
    end
  end

  // Driver side: push an expectation, let the monitor take it.
  task automatic expect_regs(string tag, logic [5:0] ea, logic [5:0] eb);
    item_t it;
    it.tag = tag; it.ea = ea; it.eb = eb;
    it.ia = ea & irq_en;  // R11
    it.ib = eb & irq_en;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    cnt_upd = 0; cmp_hit = '0; cap_edge = '0; xack = '0;
    rd_en = 0; wr_en = 0;
  endtask

  task automatic do_read();
    rd_en = 1; tick();
  endtask

  task automatic do_write(logic [5:0] d);
    wr_en = 1; wdata = d; tick();
  endtask

  task automatic cnt_step(logic [15:0] c, logic [15:0] n);
    cnt_upd = 1; cnt_cur = c; cnt_nxt = n; tick();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_regs("R1 in reset", 6'h00, 6'h00);
    rst_n = 1; tick();
    expect_regs("R1 after reset", 6'h00, 6'h00);

    cnt_step(16'hFFFE, 16'hFFFF);
    expect_regs("R2 no wrap", 6'h00, 6'h00);
    cnt_step(16'hFFFF, 16'h0000);
    expect_regs("R2 overflow", 6'h10, 6'h10);

    phase_mode = 0;
    cnt_step(16'h0000, 16'hFFFF);
    expect_regs("R3 underflow outside phase mode", 6'h10, 6'h10);
    phase_mode = 1;
    cnt_step(16'h0000, 16'hFFFF);
    expect_regs("R3 R10 underflow", 6'h10, 6'h30);

    do_write(6'h00);
    expect_regs("R5 write without read", 6'h10, 6'h30);
    do_read();
    expect_regs("R5 read has no side effect", 6'h10, 6'h30);
    do_write(6'h00);
    expect_regs("R5 armed clear", 6'h00, 6'h00);

    cap_mode = 4'b0000; cap_edge = 4'b1111; tick();
    expect_regs("R4 capture edge ignored in compare mode", 6'h00, 6'h00);
    cmp_hit = 4'b1111; tick();
    expect_regs("R4 R10 compare hit", 6'h0F, 6'h03);

    do_read();
    do_write(6'h3F);
    expect_regs("R6 write ones", 6'h0F, 6'h03);
    do_write(6'h00);
    expect_regs("R7 second write disarmed", 6'h0F, 6'h03);

    xkeep = 1; xack = 4'b1000; tick();
    expect_regs("R8 keep select", 6'h0F, 6'h03);
    xkeep = 0; xack = 4'b1000; tick();
    expect_regs("R8 transfer clear", 6'h07, 6'h03);

    cap_mode = 4'b1111; cmp_hit = 4'b1000; tick();
    expect_regs("R4 compare hit ignored in capture mode", 6'h07, 6'h03);
    cap_edge = 4'b1000; tick();
    expect_regs("R4 capture edge", 6'h0F, 6'h03);

    do_read();
    wr_en = 1; wdata = 6'h00; cap_edge = 4'b0001; xack = 4'b0001; tick();
    expect_regs("R9 set wins", 6'h01, 6'h01);

    irq_en = 6'h00;
    expect_regs("R11 irq masked", 6'h01, 6'h01);
    irq_en = 6'h01;
    expect_regs("R11 irq enabled", 6'h01, 6'h01);
    irq_en = 6'h3F;

    cmp_hit = 4'b1100; cap_mode = 4'b0000; tick();
    do_read();
    do_write(6'h00);
    expect_regs("R10 reserved stay zero", 6'h00, 6'h00);

    cnt_step(16'hFFFF, 16'h0000);
    rst_n = 0; tick();
    expect_regs("R1 reset mid-run", 6'h00, 6'h00);
    rst_n = 1; tick();

    repeat (2) @(negedge clk);
    report();
  end

endmodule